// File: doc/BRIEF.md
# Two-Wire Memory Slave Protocol Engine

This block is the byte-level engine of a serial memory slave on a two-wire bus. A front end that has already filtered and synchronised the bus lines hands it single-cycle events: a START, a STOP, a sampled data bit on each rising clock edge, and a pulse on each falling clock edge. The engine does not see the bus lines directly. It returns one registered output that, when high, pulls the data line low.

After a START the engine checks the first byte against a fixed four-bit device-type code and three strap inputs. A write command is followed by a two-byte word address, high byte first, and then by any number of data bytes. Each data byte goes out on a write-cache port, and a commit pulse at STOP launches the self-timed programming cycle. A read command fetches from a one-cycle-latency memory port, starting at the internal pointer, and keeps sending bytes for as long as the master acknowledges them. While the external write sequencer reports busy, the engine acknowledges nothing, so a master can poll until the cycle completes.

Top module: `twi_mem_slave`

## Requirements
- R1: The engine acknowledges a byte received after START (pulls SDA low for the ninth bit slot) only when bits 7..4 are 1010, bits 3..1 equal `strap_i[2:0]`, and `busy_i` is low. Bit 0 chooses the direction: 1 is read, 0 is write.
- R2: After a control byte that does not match, SDA stays released, and no write or commit happens, until the next START.
- R3: While `busy_i` is high, a matching control byte gets no acknowledge. The bytes that follow cause no acknowledge, no cache write and no commit.
- R4: After a write control byte, the engine acknowledges two address bytes. They are taken high byte first and MSB first, and the pointer becomes {high[3:0], low}. Bits 7..4 of the high byte are ignored.
- R5: Every further byte of a write command is acknowledged and issued as a one-cycle `wr_en_o` pulse carrying the current pointer and the byte. The pointer then increments by one.
- R6: `commit_o` pulses for one cycle on a STOP only if at least one data byte was written since the last START. A repeated START never commits.
- R7: A repeated START after the address bytes keeps the loaded pointer, so a following read control byte returns the byte at that address.
- R8: A read command that follows no address returns the byte at the last accessed address plus one. After reset the pointer is 0.
- R9: In a read, a master acknowledge (0 in the ninth slot) makes the engine send the next byte at pointer+1. The 12-bit pointer wraps from 4095 to 0.
- R10: After a master NACK the engine releases SDA and ignores all bits until the next START or STOP.
- R11: A START or STOP inside a byte discards the partial byte. No cache write results from it.
- R12: In and right after reset, SDA is released, `wr_en_o`, `rd_en_o` and `commit_o` are low, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt_i | input | 1 | START detected (one-cycle pulse) |
| stop_evt_i | input | 1 | STOP detected (one-cycle pulse) |
| bit_evt_i | input | 1 | Data bit sampled on rising bus clock |
| bit_val_i | input | 1 | Value of the sampled bit |
| scl_fall_i | input | 1 | Falling edge of the bus clock (one-cycle pulse) |
| strap_i | input | 3 | Device select strap pins |
| busy_i | input | 1 | Self-timed write cycle in progress |
| sda_low_o | output | 1 | 1 = pull the data line low |
| wr_en_o | output | 1 | Write-cache byte strobe |
| wr_addr_o | output | 12 | Write-cache byte address |
| wr_data_o | output | 8 | Write-cache byte data |
| commit_o | output | 1 | Start the programming cycle |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | 12 | Memory read address |
| rd_data_i | input | 8 | Memory read data, valid the cycle after `rd_en_o` |

## Verification
The bench targets these weak points:
- Pointer wrap at the top of memory. A wrong wrap would return the byte at 4096 aliased, or stall.
- The ignored high address nibble. A wrong design would write to a masked address.
- A polling control byte sent during busy. A wrong design would acknowledge early and corrupt the cycle.
- A STOP arriving mid-byte. A wrong design would commit a half-shifted byte.
- Releasing SDA after a master NACK. A design that keeps transmitting would collide with the master's STOP.

A table walks many control-byte variants against the straps. The bench also checks that the pointer survives a repeated START, and that a commit occurs only when data was actually written.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR_H,
    ST_ADDR_L,
    ST_WDATA,
    ST_TX,
    ST_WAIT
  } twi_state_e;
endpackage

// File: rtl/twi_rx_shifter.sv
module twi_rx_shifter #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          bit_evt_i,
  input  logic          bit_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [DW-1:0] byte_o,
  output logic          byte_full_o,
  output logic          ack_slot_o
);
  logic [CW-1:0] cnt_q;
  logic [DW-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_evt_i) begin
      if (cnt_q == CW'(DW)) cnt_q <= '0;
      else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= {sh_q[DW-3:0], bit_val_i};
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign byte_o      = {sh_q, bit_val_i};
  assign byte_full_o = bit_evt_i && (cnt_q == CW'(DW - 1));
  assign ack_slot_o  = bit_evt_i && (cnt_q == CW'(DW));

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DW));
endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i) |=> ptr_q == AW'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int AW = 12,
  parameter int CODE_W = 4,
  parameter int SEL_W = 3,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010,
  localparam int DW = CODE_W + SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_evt_i,
  input  logic             stop_evt_i,
  input  logic             bit_evt_i,
  input  logic             bit_val_i,
  input  logic             scl_fall_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             busy_i,
  output logic             sda_low_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             commit_o,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [DW-1:0]    rd_data_i
);
  localparam int CW   = $clog2(DW + 1);
  localparam int HI_W = AW - DW;

  twi_state_e    state_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_byte;
  logic          byte_full, ack_slot;
  logic [AW-1:0] ptr_q;
  logic          ptr_load, ptr_inc;
  logic [HI_W-1:0] hi_q;
  logic          ack_q, dirty_q, pend_q;
  logic [DW-1:0] tx_q;
  logic          ctrl_match;

  twi_rx_shifter #(.DW(DW)) rx_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (start_evt_i | stop_evt_i),
    .bit_evt_i  (bit_evt_i),
    .bit_val_i  (bit_val_i),
    .cnt_o      (cnt),
    .byte_o     (rx_byte),
    .byte_full_o(byte_full),
    .ack_slot_o (ack_slot)
  );

  always_comb begin
    ctrl_match = (rx_byte[DW-1 -: CODE_W] == DEV_CODE) &&
                 (rx_byte[SEL_W:1] == strap_i) && !busy_i;
    ptr_load   = byte_full && (state_q == ST_ADDR_L) && !start_evt_i && !stop_evt_i;
    ptr_inc    = !start_evt_i && !stop_evt_i &&
                 ((byte_full && state_q == ST_WDATA) ||
                  (ack_slot && state_q == ST_TX && !ack_q));
  end

  twi_addr_ptr #(.AW(AW)) ptr_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (ptr_load),
    .load_val_i({hi_q, rx_byte}),
    .inc_i     (ptr_inc),
    .ptr_o     (ptr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ack_q     <= 1'b0;
      dirty_q   <= 1'b0;
      pend_q    <= 1'b0;
      hi_q      <= '0;
      tx_q      <= '0;
      sda_low_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      commit_o  <= 1'b0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_en_o  <= 1'b0;
      rd_en_o  <= 1'b0;
      commit_o <= 1'b0;
      pend_q   <= rd_en_o;
      if (pend_q) tx_q <= rd_data_i;
      if (start_evt_i) begin
        state_q   <= ST_CTRL;
        ack_q     <= 1'b0;
        sda_low_o <= 1'b0;
        dirty_q   <= 1'b0;
      end else if (stop_evt_i) begin
        state_q   <= ST_IDLE;
        ack_q     <= 1'b0;
        sda_low_o <= 1'b0;
        commit_o  <= dirty_q;
        dirty_q   <= 1'b0;
      end else begin
        if (byte_full) begin
          case (state_q)
            ST_CTRL: begin
              if (ctrl_match) begin
                ack_q <= 1'b1;
                if (rx_byte[0]) begin
                  state_q   <= ST_TX;
                  rd_en_o   <= 1'b1;
                  rd_addr_o <= ptr_q;
                end else begin
                  state_q <= ST_ADDR_H;
                end
              end else begin
                state_q <= ST_WAIT;
              end
            end
            ST_ADDR_H: begin
              hi_q    <= rx_byte[HI_W-1:0];
              ack_q   <= 1'b1;
              state_q <= ST_ADDR_L;
            end
            ST_ADDR_L: begin
              ack_q   <= 1'b1;
              state_q <= ST_WDATA;
            end
            ST_WDATA: begin
              ack_q     <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_addr_o <= ptr_q;
              wr_data_o <= rx_byte;
              dirty_q   <= 1'b1;
            end
            default: ;
          endcase
        end
        if (ack_slot) begin
          ack_q <= 1'b0;
          if (state_q == ST_TX && !ack_q) begin
            if (bit_val_i) state_q <= ST_WAIT;
            else begin
              rd_en_o   <= 1'b1;
              rd_addr_o <= AW'(ptr_q + 1'b1);
            end
          end
        end
        if (scl_fall_i) begin
          if (cnt == CW'(DW)) sda_low_o <= ack_q;
          else if (state_q == ST_TX) begin
            sda_low_o <= !tx_q[DW-1];
            tx_q      <= {tx_q[DW-2:0], 1'b1};
          end else sda_low_o <= 1'b0;
        end
      end
    end
  end

  // R1
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> $past(scl_fall_i));
  // R3
  busy_noack_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_full && state_q == ST_CTRL && busy_i && !start_evt_i && !stop_evt_i) |=> !ack_q);
  // R5
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> ptr_q == AW'(wr_addr_o + 1'b1));
  // R6
  commit_stop_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(stop_evt_i));
  // R10
  nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && scl_fall_i && !start_evt_i) |=> !sda_low_o);
endmodule

// File: tb/twi_mem_slave_tb.sv
module twi_mem_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_evt = 0, stop_evt = 0, bit_evt = 0, bit_val = 0, scl_fall = 0;
  logic [2:0] strap = 3'b101;
  logic busy = 0;
  logic sda_low, wr_en, commit, rd_en;
  logic [11:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int checks = 0, errors = 0;
  int wr_cnt = 0, commit_cnt = 0;
  logic [11:0] last_wa;
  logic [7:0] last_wd;
  logic [7:0] mem [4096];

  always #10 clk = ~clk;

  twi_mem_slave dut_i (
    .clk(clk), .rst(rst), .start_evt_i(start_evt), .stop_evt_i(stop_evt),
    .bit_evt_i(bit_evt), .bit_val_i(bit_val), .scl_fall_i(scl_fall),
    .strap_i(strap), .busy_i(busy), .sda_low_o(sda_low), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .commit_o(commit),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] pat(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]};
  endfunction

  initial for (int i = 0; i < 4096; i++) mem[i] = pat(12'(i));

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_cnt  <= wr_cnt + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
    end
    if (commit) commit_cnt <= commit_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start;
    @(negedge clk); start_evt = 1; @(negedge clk); start_evt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_stop;
    @(negedge clk); stop_evt = 1; @(negedge clk); stop_evt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic low);
    @(negedge clk); low = sda_low; bit_val = b; bit_evt = 1;
    @(negedge clk); bit_evt = 0;
    repeat (3) @(negedge clk);
    scl_fall = 1; @(negedge clk); scl_fall = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
    xfer_bit(1'b1, acked);
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d, output logic any_low);
    logic s;
    any_low = 0;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, s);
      d[i] = !s;
      any_low |= s;
    end
    xfer_bit(!m_ack, s);
  endtask

  localparam logic [8:0] CTRL_VEC [8] = '{
    {8'hAA, 1'b1}, {8'hAB, 1'b1}, {8'hA8, 1'b0}, {8'hBA, 1'b0},
    {8'h2A, 1'b0}, {8'hAE, 1'b0}, {8'hEA, 1'b0}, {8'hA3, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic lw;
    logic [7:0] d;
    int wc, cc;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!sda_low && !wr_en && !commit && !rd_en, "R12", {sda_low, wr_en, commit, rd_en}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(!sda_low && !wr_en && !commit && !rd_en, "R12", {sda_low, wr_en, commit, rd_en}, 0);

    // R8 R12 read after reset starts at 0
    do_start; send_byte(8'hAB, a);
    recv_byte(1'b0, d, lw);
    chk(d == pat(12'h000), "R12", d, pat(12'h000));
    do_stop;

    // R1 control byte table
    foreach (CTRL_VEC[i]) begin
      do_start; send_byte(CTRL_VEC[i][8:1], a); do_stop;
      chk(a == CTRL_VEC[i][0], "R1", a, CTRL_VEC[i][0]);
    end

    // R4 R5 R6 write of two bytes, high nibble ignored
    wc = wr_cnt; cc = commit_cnt;
    do_start; send_byte(8'hAA, a);
    send_byte(8'hF1, a); chk(a, "R4", a, 1);
    send_byte(8'h23, a); chk(a, "R4", a, 1);
    send_byte(8'h5C, a); chk(a, "R5", a, 1);
    chk(last_wa == 12'h123 && last_wd == 8'h5C, "R4", {last_wa, last_wd}, {12'h123, 8'h5C});
    send_byte(8'hC3, a);
    chk(last_wa == 12'h124 && last_wd == 8'hC3 && wr_cnt == wc + 2, "R5", last_wa, 12'h124);
    do_stop;
    chk(commit_cnt == cc + 1, "R6", commit_cnt, cc + 1);

    // R8 current address read after write
    do_start; send_byte(8'hAB, a);
    recv_byte(1'b0, d, lw);
    chk(d == pat(12'h125), "R8", d, pat(12'h125));
    do_stop;

    // R7 R10 random read then NACK
    do_start; send_byte(8'hAA, a); send_byte(8'h01, a); send_byte(8'h23, a);
    do_start; send_byte(8'hAB, a);
    recv_byte(1'b0, d, lw);
    chk(d == 8'h5C, "R7", d, 8'h5C);
    recv_byte(1'b0, d, lw);
    chk(!lw, "R10", lw, 0);
    do_stop;

    // R9 sequential read with wrap
    do_start; send_byte(8'hAA, a); send_byte(8'h0F, a); send_byte(8'hFE, a);
    do_start; send_byte(8'hAB, a);
    recv_byte(1'b1, d, lw); chk(d == pat(12'hFFE), "R9", d, pat(12'hFFE));
    recv_byte(1'b1, d, lw); chk(d == pat(12'hFFF), "R9", d, pat(12'hFFF));
    recv_byte(1'b0, d, lw); chk(d == pat(12'h000), "R9", d, pat(12'h000));
    do_stop;

    // R3 busy: no acks, no write, no commit
    wc = wr_cnt; cc = commit_cnt; busy = 1;
    do_start; send_byte(8'hAA, a); chk(!a, "R3", a, 0);
    send_byte(8'h00, a); send_byte(8'h40, a); send_byte(8'h77, a);
    chk(!a, "R3", a, 0);
    do_stop;
    chk(wr_cnt == wc && commit_cnt == cc, "R3", wr_cnt, wc);
    busy = 0;
    do_start; send_byte(8'hAA, a); chk(a, "R3", a, 1); do_stop;
    chk(commit_cnt == cc, "R6", commit_cnt, cc);

    // R11 STOP inside a data byte
    wc = wr_cnt;
    do_start; send_byte(8'hAA, a); send_byte(8'h00, a); send_byte(8'h20, a);
    for (int i = 0; i < 4; i++) xfer_bit(1'b0, lw);
    do_stop;
    chk(wr_cnt == wc && commit_cnt == cc, "R11", wr_cnt, wc);
    do_start; send_byte(8'hAB, a);
    recv_byte(1'b0, d, lw);
    chk(d == pat(12'h020), "R11", d, pat(12'h020));
    do_stop;

    // R2 mismatched strap: silent, no write
    wc = wr_cnt;
    do_start; send_byte(8'hA2, a); chk(!a, "R2", a, 0);
    send_byte(8'h00, a); send_byte(8'h40, a); send_byte(8'h99, a);
    chk(!a && wr_cnt == wc, "R2", a, 0);
    do_stop;
    chk(commit_cnt == cc, "R2", commit_cnt, cc);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule